// File: doc/BRIEF.md
# Sequential Combination Lock Controller

This block is a clocked lock controller that releases only after three entered values arrive in the right order. Three stored combination digits are presented on separate inputs. The controller steps through them one at a time. A multiplexer steered by the controller picks the digit for the current step, and one shared equality comparator checks it against the value on the entry bus. The comparator's match result goes back into the controller and decides the next state.

A value counts only on a clock edge where the entry strobe is high. A match moves the controller one step forward, and the third match unlocks. A mismatch at any step sends the controller to a fault state. The lock then stays closed, whatever is entered later, until a synchronous reset returns it to wait for the first digit. The unlocked output is registered, so it changes only on the rising clock edge.

Top module: `seq_combo_lock`

## Requirements
- R1: While `rst` is high at a rising edge, the controller goes back to waiting for the first digit, and `unlocked` reads 0 after that edge.
- R2: On an edge where `entry_stb` is low, the value on `entry_val` is ignored and the controller's progress does not change.
- R3: A strobed value equal to the digit for the current step (first `code_a`, then `code_b`, then `code_c`) advances one step and leaves `unlocked` at 0 until the third match.
- R4: `unlocked` rises on the same edge that samples the third strobed match in sequence, and not before.
- R5: A strobed value that differs from the current step's digit enters the fault state. From there, no later entries raise `unlocked`, including a complete correct sequence.
- R6: Once `unlocked` is high it stays high, whatever strobed or idle values follow, until reset.
- R7: A match requires all `DIGIT_W` bits to be equal. A value that differs only in its most significant bit is a mismatch.
- R8: A reset from either the unlocked state or the fault state lets a fresh correct sequence unlock again.
- R9: The digits must be entered in step order. The correct values entered in any other order do not unlock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| entry_stb | input | 1 | High for one cycle per entered value |
| entry_val | input | DIGIT_W | Entered value, sampled when `entry_stb` is high |
| code_a | input | DIGIT_W | First combination digit |
| code_b | input | DIGIT_W | Second combination digit |
| code_c | input | DIGIT_W | Third combination digit |
| unlocked | output | 1 | Registered; high only in the unlocked state |

## Verification
The bench targets the stickiness of both end states. A design that restarted after a wrong value would open on the correct triple that follows a mismatch. A design that dropped out of the unlocked state would close on the next stray entry. The bench also places idle cycles between strobes carrying values that would fail a compare; a controller that ignored the strobe would fault on them. Finally, it checks an entry that differs only in its top bit, which a truncated compare would accept, and a reversed-order entry, which a design with a mis-steered multiplexer would accept.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;

    localparam int STEPS = 3;
    localparam int SEL_W = $clog2(STEPS);

    typedef enum logic [2:0] {
        LK_WAIT1 = 3'd0,
        LK_WAIT2 = 3'd1,
        LK_WAIT3 = 3'd2,
        LK_OPEN  = 3'd4,
        LK_FAULT = 3'd5
    } lock_state_e;

    typedef logic [SEL_W-1:0] step_sel_t;

    function automatic logic is_comparing(lock_state_e s);
        return (s == LK_WAIT1) || (s == LK_WAIT2) || (s == LK_WAIT3);
    endfunction

    function automatic step_sel_t step_of(lock_state_e s);
        case (s)
            LK_WAIT2: return step_sel_t'(1);
            LK_WAIT3: return step_sel_t'(2);
            default:  return step_sel_t'(0);
        endcase
    endfunction

    function automatic lock_state_e advance(lock_state_e s);
        case (s)
            LK_WAIT1: return LK_WAIT2;
            LK_WAIT2: return LK_WAIT3;
            LK_WAIT3: return LK_OPEN;
            default:  return s;
        endcase
    endfunction

endpackage

// File: rtl/combo_digit_mux.sv
module combo_digit_mux #(
    parameter int DIGIT_W = 4,
    parameter int N       = 3,
    localparam int SW     = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][DIGIT_W-1:0] digits,
    input  logic [SW-1:0]             sel,
    output logic [DIGIT_W-1:0]        digit_out
);

    always_comb begin
        digit_out = '0;
        for (int i = 0; i < N; i++) begin
            if (sel == SW'(i)) digit_out = digits[i];
        end
    end

endmodule

// File: rtl/combo_eq_cmp.sv
module combo_eq_cmp #(
    parameter int DIGIT_W = 4
) (
    input  logic [DIGIT_W-1:0] lhs,
    input  logic [DIGIT_W-1:0] rhs,
    output logic               equal
);

    logic [DIGIT_W-1:0] bit_same;

    for (genvar b = 0; b < DIGIT_W; b++) begin : g_bit
        assign bit_same[b] = ~(lhs[b] ^ rhs[b]);
    end

    assign equal = &bit_same;

endmodule

// File: rtl/combo_lock_ctrl.sv
module combo_lock_ctrl
    import combo_lock_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      stb,
    input  logic      eq,
    output step_sel_t sel,
    output logic      unlocked
);

    lock_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (stb && is_comparing(state_q)) begin
            state_d = eq ? advance(state_q) : LK_FAULT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= LK_WAIT1;
            unlocked <= 1'b0;
        end else begin
            state_q  <= state_d;
            unlocked <= (state_d == LK_OPEN);
        end
    end

    assign sel = step_of(state_q);

    // R1
    a_r1_reset_closed: assert property (@(posedge clk)
        $fell(rst) |-> (state_q == LK_WAIT1) && !unlocked);

    // R2
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(state_q));

    // R4
    a_r4_open_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> ($past(state_q) == LK_WAIT3) && $past(stb) && $past(eq));

    // R5
    a_r5_mismatch_faults: assert property (@(posedge clk) disable iff (rst)
        (stb && !eq && is_comparing(state_q)) |=> (state_q == LK_FAULT));

    a_r5_fault_sticky: assert property (@(posedge clk) disable iff (rst)
        (state_q == LK_FAULT) |=> (state_q == LK_FAULT) && !unlocked);

    // R6
    a_r6_open_sticky: assert property (@(posedge clk) disable iff (rst)
        unlocked |=> unlocked);

endmodule

// File: rtl/seq_combo_lock.sv
module seq_combo_lock
    import combo_lock_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               entry_stb,
    input  logic [DIGIT_W-1:0] entry_val,
    input  logic [DIGIT_W-1:0] code_a,
    input  logic [DIGIT_W-1:0] code_b,
    input  logic [DIGIT_W-1:0] code_c,
    output logic               unlocked
);

    logic [STEPS-1:0][DIGIT_W-1:0] digits;
    logic [DIGIT_W-1:0]            cur_digit;
    step_sel_t                     sel;
    logic                          eq;

    assign digits = {code_c, code_b, code_a};

    combo_digit_mux #(.DIGIT_W(DIGIT_W), .N(STEPS)) u_mux (
        .digits    (digits),
        .sel       (sel),
        .digit_out (cur_digit)
    );

    combo_eq_cmp #(.DIGIT_W(DIGIT_W)) u_cmp (
        .lhs   (cur_digit),
        .rhs   (entry_val),
        .equal (eq)
    );

    combo_lock_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .stb      (entry_stb),
        .eq       (eq),
        .sel      (sel),
        .unlocked (unlocked)
    );

    // R7: a full-width match is needed at the comparator
    a_r7_full_compare: assert property (@(posedge clk) disable iff (rst)
        eq |-> (cur_digit == entry_val));

endmodule

// File: tb/tb_seq_combo_lock.sv
`timescale 1ns/1ps
module tb_seq_combo_lock;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         entry_stb = 1'b0;
    logic [W-1:0] entry_val = '0;
    logic [W-1:0] code_a = '0, code_b = '0, code_c = '0;
    logic         unlocked;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    seq_combo_lock #(.DIGIT_W(W)) dut (
        .clk(clk), .rst(rst), .entry_stb(entry_stb), .entry_val(entry_val),
        .code_a(code_a), .code_b(code_b), .code_c(code_c), .unlocked(unlocked)
    );

    // {code_a, code_b, code_c, entry1, entry2, entry3, expected unlocked}
    localparam int NV = 9;
    localparam logic [24:0] VEC [NV] = '{
        {12'h371, 12'h371, 1'b1},
        {12'h371, 12'h471, 1'b0},
        {12'h371, 12'h361, 1'b0},
        {12'h371, 12'h370, 1'b0},
        {12'h000, 12'h000, 1'b1},
        {12'hFFF, 12'hFFF, 1'b1},
        {12'h555, 12'hD55, 1'b0},
        {12'h92E, 12'h92E, 1'b1},
        {12'hABC, 12'hCBA, 1'b0}
    };

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: unlocked=%0b expected=%0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; entry_stb = 1'b0;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic enter(input logic [W-1:0] v);
        @(negedge clk); entry_stb = 1'b1; entry_val = v;
        @(negedge clk); entry_stb = 1'b0;
    endtask

    task automatic idle(input int n, input logic [W-1:0] v);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); entry_stb = 1'b0; entry_val = v;
        end
    endtask

    task automatic set_code(input logic [11:0] c);
        code_a = c[11:8]; code_b = c[7:4]; code_c = c[3:0];
    endtask

    initial begin
        // R1: reset state
        do_reset();
        check(unlocked, 1'b0, "R1 reset state");

        // Vector table: R3 R4 R5 R7 R9
        for (int k = 0; k < NV; k++) begin
            do_reset();
            set_code(VEC[k][24:13]);
            enter(VEC[k][12:9]);
            enter(VEC[k][8:5]);
            enter(VEC[k][4:1]);
            check(unlocked, VEC[k][0], $sformatf("R4/R5/R7/R9 vector %0d", k));
        end

        // R3 / R2 / R4: step-by-step with idle gaps
        do_reset();
        set_code(12'h371);
        enter(4'h3);
        check(unlocked, 1'b0, "R3 after first match");
        idle(3, 4'h9);
        enter(4'h7);
        check(unlocked, 1'b0, "R3 after second match");
        idle(4, 4'h0);
        check(unlocked, 1'b0, "R2 idle values ignored");
        enter(4'h1);
        check(unlocked, 1'b1, "R4 third match unlocks");

        // R6: stays open on later entries
        enter(4'h0);
        check(unlocked, 1'b1, "R6 open after wrong entry");
        enter(4'hF);
        idle(3, 4'h5);
        check(unlocked, 1'b1, "R6 open after more entries");

        // R8: reset from open
        do_reset();
        check(unlocked, 1'b0, "R8 reset closes open lock");
        enter(4'h3); enter(4'h7); enter(4'h1);
        check(unlocked, 1'b1, "R8 reopens after reset");

        // R5: fault is sticky against a full correct sequence
        do_reset();
        enter(4'h3); enter(4'h0);
        enter(4'h3); enter(4'h7); enter(4'h1);
        check(unlocked, 1'b0, "R5 fault ignores correct sequence");
        enter(4'h7); enter(4'h1);
        check(unlocked, 1'b0, "R5 fault still closed");

        // R5: wrong third then the right third
        do_reset();
        enter(4'h3); enter(4'h7); enter(4'h2); enter(4'h1);
        check(unlocked, 1'b0, "R5 late correct after wrong third");

        // R8: reset from fault
        do_reset();
        enter(4'h3); enter(4'h7); enter(4'h1);
        check(unlocked, 1'b1, "R8 unlock after reset from fault");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule